// File: doc/BRIEF.md
# Debug Register Bank Target

This block is the far end of a debug module link: a master (normally fed by a scan chain) reaches a small bank of data registers through a four-phase request/acknowledge handshake. The master raises the request and, in the same cycle, presents the address, the write data and a write-enable. The target takes all of them on the clock edge where it first sees the request while it is idle. On that edge it either writes the addressed register or copies the addressed register's value into a read-data holding register.

The target then raises acknowledge. It holds acknowledge and read data steady for as long as the master keeps the request high. When the request falls, acknowledge falls on the next edge. The target then spends one more cycle with acknowledge low before it accepts another request. The interface inputs are ignored while a transaction is open. Addresses beyond the implemented register count read as zero and drop writes, but they complete the handshake normally.

Top module: `dbg_regbank_target`

## Requirements
- R1: A synchronous active-high reset clears every register in the bank to zero, drives acknowledge low and read data to zero, and returns the target to idle.
- R2: On a clock edge where the target is idle and the request is high, the address, write data and write-enable are captured. Acknowledge is high from the following cycle.
- R3: Acknowledge stays high on every edge that sees the request high. It goes low on the first edge after which the request was sampled low.
- R4: Read data changes only when a read is captured. Read data keeps one value while acknowledge is high, and later write transactions leave it unchanged.
- R5: Write-enable high selects a write of the write data into the addressed register. Write-enable low selects a read that returns the addressed register's current contents.
- R6: An address equal to or above the register count (default 16) reads as zero and leaves every register unchanged on a write. Acknowledge still rises and falls as for any other address.
- R7: After acknowledge falls, it stays low for at least one further cycle, even if the request rises again at once. A request is accepted only once the target is back in idle.
- R8: Changes on address, write data or write-enable while a transaction is open have no effect on the bank or on read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Transaction request from the master |
| we | input | 1 | 1 = write, 0 = read; sampled with the request |
| addr | input | ADDR_W (8) | Register address |
| wdata | input | DATA_W (64) | Write data |
| ack | output | 1 | Transaction acknowledge |
| rdata | output | DATA_W (64) | Held read data |

## Verification
The bench scrambles address, write data and write-enable while acknowledge is high and then reads the bank back. A target that sampled its inputs every cycle instead of once would corrupt a register or report the wrong word. It follows a read of a register with a write to that same register and checks that the held read data does not move; a design that read through to the live register would show the new value. It raises the request again in the very cycle acknowledge falls, which catches a target that skips its return-to-idle cycle. It also writes and reads above the register count, where a design that truncated the address would alias onto a real register.

// File: rtl/dbgt_pkg.sv
package dbgt_pkg;

   typedef enum logic [1:0] {
      HS_IDLE = 2'd0,
      HS_ACK  = 2'd1,
      HS_DONE = 2'd2
   } hs_state_t;

endpackage

// File: rtl/dbgt_hs_fsm.sv
module dbgt_hs_fsm
   import dbgt_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic req,
   output logic capture,
   output logic ack
);

   hs_state_t state_q, state_d;

   // accept a request only from the idle state
   assign capture = (state_q == HS_IDLE) && req;
   assign ack     = (state_q == HS_ACK);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         HS_IDLE: if (req)  state_d = HS_ACK;
         HS_ACK:  if (!req) state_d = HS_DONE;
         HS_DONE:           state_d = HS_IDLE;
         default:           state_d = HS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= HS_IDLE;
      else     state_q <= state_d;
   end

   assert_ack_rise_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(ack) |-> $past(req));

   assert_ack_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (ack && req) |=> ack);

   assert_ack_fall_R3: assert property (@(posedge clk) disable iff (rst)
      (ack && !req) |=> !ack);

   assert_idle_gap_R7: assert property (@(posedge clk) disable iff (rst)
      $fell(ack) |=> !ack);

endmodule

// File: rtl/dbgt_regfile.sv
module dbgt_regfile #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 64,
   parameter int NUM_REGS = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] bank_q [NUM_REGS];

   for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(gi);

      always_ff @(posedge clk) begin
         if (rst)                            bank_q[gi] <= '0;
         else if (wr_en && addr == MY_ADDR)  bank_q[gi] <= wdata;
      end

      assert_reg_untouched_R6: assert property (@(posedge clk) disable iff (rst)
         (!wr_en || addr != MY_ADDR) |=> $stable(bank_q[gi]));
   end

   // decoded read mux; no match above the bank yields zero
   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (addr == ADDR_W'(i)) rd_data = bank_q[i];
      end
   end

endmodule

// File: rtl/dbgt_rd_hold.sv
module dbgt_rd_hold #(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);

   always_ff @(posedge clk) begin
      if (rst)       dout <= '0;
      else if (load) dout <= din;
   end

endmodule

// File: rtl/dbg_regbank_target.sv
module dbg_regbank_target #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 64,
   parameter int NUM_REGS = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              ack,
   output logic [DATA_W-1:0] rdata
);

   if (ADDR_W < 1 || ADDR_W > 30) begin : g_bad_addr_w
      $error("dbg_regbank_target: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("dbg_regbank_target: DATA_W must be positive");
   end
   if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_num_regs
      $error("dbg_regbank_target: NUM_REGS must fit the address space");
   end

   logic              capture;
   logic              do_write;
   logic              do_read;
   logic [DATA_W-1:0] bank_rd;

   dbgt_hs_fsm u_fsm (
      .clk     (clk),
      .rst     (rst),
      .req     (req),
      .capture (capture),
      .ack     (ack)
   );

   assign do_write = capture && we;
   assign do_read  = capture && !we;

   dbgt_regfile #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS)
   ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (do_write),
      .addr    (addr),
      .wdata   (wdata),
      .rd_data (bank_rd)
   );

   dbgt_rd_hold #(
      .DATA_W (DATA_W)
   ) u_hold (
      .clk  (clk),
      .rst  (rst),
      .load (do_read),
      .din  (bank_rd),
      .dout (rdata)
   );

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (!ack && rdata == '0));

   assert_rdata_stable_R4: assert property (@(posedge clk) disable iff (rst)
      (ack && $past(ack)) |-> $stable(rdata));

   assert_write_keeps_rdata_R4: assert property (@(posedge clk) disable iff (rst)
      (capture && we) |=> $stable(rdata));

endmodule

// File: tb/sim_dbg_regbank_target.sv
module sim_dbg_regbank_target;

   localparam int CLK_PERIOD = 10;
   localparam int NREG       = 16;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req = 1'b0;
   logic        we = 1'b0;
   logic [7:0]  addr = '0;
   logic [63:0] wdata = '0;
   logic        ack;
   logic [63:0] rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [63:0] model [NREG];

   always #(CLK_PERIOD/2) clk = ~clk;

   dbg_regbank_target u0 (
      .clk   (clk),
      .rst   (rst),
      .req   (req),
      .we    (we),
      .addr  (addr),
      .wdata (wdata),
      .ack   (ack),
      .rdata (rdata)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // one full handshake; inputs are scrambled while ack is high (R8)
   task automatic txn(input logic w, input logic [7:0] a, input logic [63:0] d,
                      input int hold);
      logic [63:0] exp;
      @(negedge clk);
      exp = w ? rdata : ((a < NREG) ? model[a] : 64'h0);
      req = 1'b1; we = w; addr = a; wdata = d;
      @(negedge clk);
      chk("R2 ack after capture", {63'h0, ack}, 64'h1);
      chk(w ? "R4 rdata kept on write" : "R5 read value", rdata, exp);
      if (w && a < NREG) model[a] = d;
      we = ~w; addr = ~a; wdata = ~d;
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         chk("R3 ack held", {63'h0, ack}, 64'h1);
         chk("R4 rdata stable", rdata, exp);
      end
      req = 1'b0;
      @(negedge clk);
      chk("R3 ack fall", {63'h0, ack}, 64'h0);
   endtask

   task automatic read_exp(input logic [7:0] a, input string tag, input logic [63:0] exp);
      txn(1'b0, a, 64'h0, 1);
      chk(tag, rdata, exp);
   endtask

   task automatic t_reset();
      chk("R1 ack low after reset", {63'h0, ack}, 64'h0);
      chk("R1 rdata zero after reset", rdata, 64'h0);
      for (int r = 0; r < 4; r++) read_exp(8'(r), "R1 reg cleared", 64'h0);
   endtask

   task automatic t_write_read();
      txn(1'b1, 8'd0, 64'h0123_4567_89ab_cdef, 0);
      txn(1'b1, 8'd15, 64'hffff_0000_ffff_0000, 2);
      txn(1'b1, 8'd7, 64'hdead_beef_cafe_f00d, 1);
      read_exp(8'd0, "R5 readback reg0", 64'h0123_4567_89ab_cdef);
      read_exp(8'd15, "R5 readback reg15", 64'hffff_0000_ffff_0000);
      read_exp(8'd7, "R5 readback reg7", 64'hdead_beef_cafe_f00d);
   endtask

   task automatic t_read_latch();
      txn(1'b1, 8'd3, 64'h3333_3333_3333_3333, 0);
      txn(1'b0, 8'd3, 64'h0, 4);
      txn(1'b1, 8'd3, 64'h4444_4444_4444_4444, 1);
      chk("R4 rdata after later write", rdata, 64'h3333_3333_3333_3333);
      read_exp(8'd3, "R5 new value visible", 64'h4444_4444_4444_4444);
   endtask

   task automatic t_out_of_range();
      txn(1'b1, 8'd200, 64'haaaa_bbbb_cccc_dddd, 1);
      read_exp(8'd200, "R6 out of range reads zero", 64'h0);
      read_exp(8'd16, "R6 first unimplemented reads zero", 64'h0);
      read_exp(8'd8, "R6 aliased reg untouched", 64'h0);
   endtask

   task automatic t_scramble();
      txn(1'b1, 8'd5, 64'h5555_aaaa_5555_aaaa, 3);
      read_exp(8'd5, "R8 captured data written", 64'h5555_aaaa_5555_aaaa);
      // read of reg6 with we/wdata flipped during ack must not write
      txn(1'b0, 8'd6, 64'h0, 3);
      read_exp(8'd6, "R8 no write during read", 64'h0);
   endtask

   task automatic t_back_to_back();
      @(negedge clk);
      req = 1'b1; we = 1'b1; addr = 8'd9; wdata = 64'h9999;
      @(negedge clk);
      chk("R2 ack b2b", {63'h0, ack}, 64'h1);
      req = 1'b0;
      @(negedge clk);
      chk("R3 ack fell b2b", {63'h0, ack}, 64'h0);
      req = 1'b1; we = 1'b0; addr = 8'd9;
      @(negedge clk);
      chk("R7 gap cycle ack low", {63'h0, ack}, 64'h0);
      @(negedge clk);
      chk("R7 accepted from idle", {63'h0, ack}, 64'h1);
      chk("R7 read after gap", rdata, 64'h9999);
      model[9] = 64'h9999;
      req = 1'b0;
      @(negedge clk);
      chk("R3 ack fall after gap txn", {63'h0, ack}, 64'h0);
   endtask

   task automatic t_reset_mid();
      txn(1'b1, 8'd2, 64'h2222, 0);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      for (int r = 0; r < NREG; r++) model[r] = 64'h0;
      chk("R1 ack low after second reset", {63'h0, ack}, 64'h0);
      read_exp(8'd2, "R1 reg cleared by reset", 64'h0);
   endtask

   initial begin
      for (int r = 0; r < NREG; r++) model[r] = 64'h0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_write_read();
      t_read_latch();
      t_out_of_range();
      t_scramble();
      t_back_to_back();
      t_reset_mid();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule